// File: doc/BRIEF.md
# Selectable Power-Up Sequencer

This block decides the order in which three switch-mode regulator channels are allowed to begin their soft-start: a 3.3 V buck, a 5 V buck and an adjustable output. A two-bit strap picks which buck goes first. The adjustable channel always goes last. Each later channel is enabled only after the channel before it reports that its output is within tolerance. The in-tolerance flags come from external comparators.

A run level turns the sequence on and off. The strap is captured when run rises, and later strap changes are ignored until run has been low and high again. The block also raises a flag while the reference-strap option (the high-impedance error-detect mode) is in force. It issues a one-cycle pulse when the second channel first reaches tolerance, so that a downstream power-good timer can start from that point. Enable bit positions are fixed: bit 0 is the 3.3 V buck, bit 1 is the 5 V buck and bit 2 is the adjustable channel. The same positions apply to the in-tolerance flags.

Top module: `pwr_seq_order`

## Requirements
- R1: While the synchronous active-low reset is asserted, and in the first cycle after it, all enables, the error-detect flag and the pulse are low.
- R2: With strap code 00 (ground option), enable bit 1 (5 V) comes on first, then bit 0 (3.3 V), then bit 2 (adjustable).
- R3: With strap code 10 (logic-supply option), enable bit 0 comes on first, then bit 1, then bit 2, and the error-detect flag stays low.
- R4: With strap code 01 (reference option), the order is the same as for code 10, and the error-detect flag is high for as long as the sequence runs.
- R5: Strap code 11 behaves exactly like code 00, with the error-detect flag low.
- R6: The first enable rises one cycle after run is sampled high. The second channel's enable rises one cycle after the first channel's in-tolerance flag is sampled high, and not before.
- R7: The adjustable channel's enable rises one cycle after the second channel's in-tolerance flag is sampled high, and not before.
- R8: One cycle after run is sampled low, all enables, the error-detect flag and the pulse are low. They stay low while run is low, whatever the flags do.
- R9: The strap is sampled in the cycle in which run is first seen high. Strap changes during a run do not change the order or the flag. A new run samples the strap again.
- R10: The pulse is high for exactly one cycle, in the cycle in which the adjustable enable first rises. It is not repeated within the same run.
- R11: In-tolerance flags of channels that are not being waited on have no effect. While run stays high, an enable that is on never drops, even if its flag falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_i | input | 1 | Run level; low holds all channels off |
| strap_i | input | 2 | Order select: 00 ground, 01 reference, 10 logic supply, 11 as 00 |
| good_i | input | 3 | In-tolerance flags: bit0 3.3 V, bit1 5 V, bit2 adjustable |
| en_o | output | 3 | Soft-start enables, same bit positions as good_i |
| hiz_mode_o | output | 1 | High-impedance error-detect mode active |
| second_good_pulse_o | output | 1 | One-cycle mark: second channel reached tolerance |

## Verification
The bench raises the in-tolerance flag of the channel that comes later, and of the adjustable channel, while the sequencer is still waiting on the first channel. A design that tests any flag, or the wrong bit for the selected order, would enable early. It changes the strap in the middle of a run and then checks both the order and the error-detect flag. A design that decodes the live strap would swap channels or toggle the flag. It drops run partway through a sequence, holds flags high while run is low, and restarts with a different strap. A design that keeps stale state would resume at the old stage or keep the old order. It also lowers and raises the second flag after completion. A pulse that is not gated to the stage transition would fire again.

// File: rtl/seq_pkg.sv
// Shared types and constants for the power-up sequencer.
// Assumes three channels in fixed bit positions: 3.3 V buck, 5 V buck, adjustable.
package seq_pkg;
    localparam int NCH     = 3;
    localparam int STRAP_W = 2;
    localparam int CHW     = $clog2(NCH);

    localparam int CH_LOW  = 0;   // 3.3 V buck
    localparam int CH_HIGH = 1;   // 5 V buck
    localparam int CH_ADJ  = 2;   // adjustable rail, always last

    localparam logic [STRAP_W-1:0] STRAP_GND = 2'b00;
    localparam logic [STRAP_W-1:0] STRAP_REF = 2'b01;
    localparam logic [STRAP_W-1:0] STRAP_VL  = 2'b10;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2,
        ST_ALL    = 2'd3
    } stage_t;
endpackage

// File: rtl/seq_order_decode.sv
// Maps the captured strap code to the first and second buck channel
// and the error-detect flag. Purely combinational; assumes the code is
// held stable by the stage controller for the whole run.
module seq_order_decode
    import seq_pkg::*;
#(
    parameter int SW = STRAP_W,
    parameter int IW = CHW
) (
    input  logic [SW-1:0] strap_q_i,
    output logic [IW-1:0] first_idx_o,
    output logic [IW-1:0] second_idx_o,
    output logic          hiz_o
);
    localparam logic [IW-1:0] IDX_LOW  = IW'(CH_LOW);
    localparam logic [IW-1:0] IDX_HIGH = IW'(CH_HIGH);

    // Select order; the unused code falls through to the ground option.
    always_comb begin
        first_idx_o  = IDX_HIGH;
        second_idx_o = IDX_LOW;
        hiz_o        = 1'b0;
        if (strap_q_i == STRAP_VL || strap_q_i == STRAP_REF) begin
            first_idx_o  = IDX_LOW;
            second_idx_o = IDX_HIGH;
            hiz_o        = (strap_q_i == STRAP_REF);
        end
    end

    // R2 R3 order variants always name two different bucks.
    always_comb begin
        assert_distinct_order_R3: assert (first_idx_o != second_idx_o);
    end
endmodule

// File: rtl/seq_stage_fsm.sv
// Stage controller: idle, first channel, second channel, all channels.
// Captures the strap when leaving idle and raises a one-cycle pulse on
// the step into the final stage. Run low returns to idle in one clock.
module seq_stage_fsm
    import seq_pkg::*;
#(
    parameter int SW = STRAP_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic [SW-1:0] strap_i,
    input  logic          first_good_i,
    input  logic          second_good_i,
    output stage_t        stage_o,
    output logic [SW-1:0] strap_q_o,
    output logic          second_pulse_o
);
    stage_t        stage_q;
    logic [SW-1:0] strap_q;
    logic          pulse_q;

    // Advance the stage, capture the strap, and form the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= ST_IDLE;
            strap_q <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            if (!run_i) begin
                stage_q <= ST_IDLE;
            end else begin
                case (stage_q)
                    ST_IDLE: begin
                        stage_q <= ST_FIRST;
                        strap_q <= strap_i;
                    end
                    ST_FIRST:  if (first_good_i) stage_q <= ST_SECOND;
                    ST_SECOND: if (second_good_i) begin
                        stage_q <= ST_ALL;
                        pulse_q <= 1'b1;
                    end
                    default:   stage_q <= ST_ALL;
                endcase
            end
        end
    end

    assign stage_o        = stage_q;
    assign strap_q_o      = strap_q;
    assign second_pulse_o = pulse_q;

    // R6 second stage entered only after first flag seen.
    assert_second_waits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stage_q) == ST_FIRST && stage_q == ST_SECOND) |-> $past(first_good_i));

    // R7 final stage entered only after second flag seen.
    assert_third_waits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stage_q) == ST_SECOND && stage_q == ST_ALL) |-> $past(second_good_i));

    // R9 captured strap stays put for the whole run.
    assert_strap_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_q != ST_IDLE && $past(stage_q) != ST_IDLE) |-> $stable(strap_q));

    // R10 pulse lasts one cycle.
    assert_pulse_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |=> !pulse_q);
endmodule

// File: rtl/seq_enable_map.sv
// Turns the stage and the decoded order into per-channel enables.
// Enables are cumulative: a later stage keeps the earlier channels on.
module seq_enable_map
    import seq_pkg::*;
#(
    parameter int N  = NCH,
    parameter int IW = CHW
) (
    input  stage_t         stage_i,
    input  logic [IW-1:0]  first_idx_i,
    input  logic [IW-1:0]  second_idx_i,
    output logic [N-1:0]   en_o
);
    logic first_on, second_on, all_on;

    // Stage levels that each channel class needs.
    always_comb begin
        first_on  = (stage_i != ST_IDLE);
        second_on = (stage_i == ST_SECOND) || (stage_i == ST_ALL);
        all_on    = (stage_i == ST_ALL);
    end

    for (genvar k = 0; k < N; k++) begin : g_ch
        if (k == CH_ADJ) begin : g_adj
            assign en_o[k] = all_on;
        end else begin : g_buck
            assign en_o[k] = (first_on  && first_idx_i  == IW'(k)) ||
                             (second_on && second_idx_i == IW'(k));
        end
    end

    // R6 exactly one channel runs during the first stage.
    always_comb begin
        if (stage_i == ST_FIRST) assert_one_in_first_R6: assert ($countones(en_o) == 1);
    end
endmodule

// File: rtl/pwr_seq_order.sv
// Top of the selectable power-up sequencer. Orders the soft-start
// enables of two bucks and an adjustable rail from a strap and per-channel
// in-tolerance flags. Assumes the flags are synchronous to clk.
module pwr_seq_order
    import seq_pkg::*;
#(
    parameter int N  = NCH,
    parameter int SW = STRAP_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic [SW-1:0] strap_i,
    input  logic [N-1:0]  good_i,
    output logic [N-1:0]  en_o,
    output logic          hiz_mode_o,
    output logic          second_good_pulse_o
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    stage_t        stage;
    logic [SW-1:0] strap_q;
    logic [IW-1:0] first_idx, second_idx;
    logic          hiz_dec;
    logic          first_good, second_good;

    // Pick the flags of the channels currently being waited on.
    always_comb begin
        first_good  = good_i[first_idx];
        second_good = good_i[second_idx];
    end

    seq_stage_fsm #(.SW(SW)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .run_i          (run_i),
        .strap_i        (strap_i),
        .first_good_i   (first_good),
        .second_good_i  (second_good),
        .stage_o        (stage),
        .strap_q_o      (strap_q),
        .second_pulse_o (second_good_pulse_o)
    );

    seq_order_decode #(.SW(SW), .IW(IW)) u_dec (
        .strap_q_i    (strap_q),
        .first_idx_o  (first_idx),
        .second_idx_o (second_idx),
        .hiz_o        (hiz_dec)
    );

    seq_enable_map #(.N(N), .IW(IW)) u_map (
        .stage_i      (stage),
        .first_idx_i  (first_idx),
        .second_idx_i (second_idx),
        .en_o         (en_o)
    );

    assign hiz_mode_o = hiz_dec && (stage != ST_IDLE);

    // R8 run low clears every output one clock later.
    assert_run_low_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (en_o == '0 && !hiz_mode_o && !second_good_pulse_o));

    // R11 enables never drop while run stays high.
    assert_enables_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && $past(run_i)) |-> ((en_o & $past(en_o)) == $past(en_o)));
endmodule

// File: tb/sim_pwr_seq_order.sv
module sim_pwr_seq_order;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_i = 1'b0;
    logic [1:0] strap_i = 2'b00;
    logic [2:0] good_i = 3'b000;
    logic [2:0] en_o;
    logic       hiz_mode_o;
    logic       second_good_pulse_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pwr_seq_order u0 (
        .clk(clk), .rst_n(rst_n), .run_i(run_i), .strap_i(strap_i),
        .good_i(good_i), .en_o(en_o), .hiz_mode_o(hiz_mode_o),
        .second_good_pulse_o(second_good_pulse_o)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; run_i = 1'b1; good_i = 3'b111;
        step(); step();
        chk("R1", "en in reset", int'(en_o), 0);
        chk("R1", "hiz in reset", int'(hiz_mode_o), 0);
        chk("R1", "pulse in reset", int'(second_good_pulse_o), 0);
        run_i = 1'b0; good_i = 3'b000;
        rst_n = 1'b1;
        step();
        chk("R1", "en after reset", int'(en_o), 0);
    endtask

    // One full run for a strap code; first/second are buck bit positions.
    task automatic t_order(input logic [1:0] code, input int first, input int second,
                           input int hiz, input string req);
        int fb = 1 << first;
        int sb = 1 << second;
        run_i = 1'b0; good_i = 3'b000; step(); step();
        strap_i = code; run_i = 1'b1;
        step();
        chk(req, "first enable", int'(en_o), fb);
        chk("R4", "hiz while running", int'(hiz_mode_o), hiz);
        good_i = 3'(sb | 4);
        step();
        chk("R11", "later flags ignored", int'(en_o), fb);
        good_i = 3'(fb);
        step();
        chk("R6", "second enable", int'(en_o), fb | sb);
        chk("R10", "no early pulse", int'(second_good_pulse_o), 0);
        strap_i = ~code;
        good_i = 3'(fb | sb);
        step();
        chk("R7", "adjustable enable", int'(en_o), 7);
        chk("R10", "pulse on second good", int'(second_good_pulse_o), 1);
        chk("R9", "hiz ignores strap change", int'(hiz_mode_o), hiz);
        step();
        chk("R10", "pulse one cycle", int'(second_good_pulse_o), 0);
        good_i = 3'b000;
        step();
        chk("R11", "enables sticky", int'(en_o), 7);
        good_i = 3'(sb);
        step();
        chk("R10", "no repeat pulse", int'(second_good_pulse_o), 0);
        run_i = 1'b0;
        step();
        chk("R8", "run low clears en", int'(en_o), 0);
        chk("R8", "run low clears hiz", int'(hiz_mode_o), 0);
        good_i = 3'b111;
        step(); step();
        chk("R8", "held off while low", int'(en_o), 0);
        good_i = 3'b000;
    endtask

    task automatic t_abort_and_resample();
        run_i = 1'b0; good_i = 3'b000; step();
        strap_i = 2'b10; run_i = 1'b1;
        step();
        chk("R3", "abort run first", int'(en_o), 1);
        good_i = 3'b001;
        step();
        chk("R3", "abort run second", int'(en_o), 3);
        run_i = 1'b0;
        step();
        chk("R8", "mid-run abort", int'(en_o), 0);
        chk("R8", "no pulse on abort", int'(second_good_pulse_o), 0);
        good_i = 3'b000; strap_i = 2'b00; run_i = 1'b1;
        step();
        chk("R9", "new strap resampled", int'(en_o), 2);
        chk("R2", "restart from first stage", int'(en_o), 2);
        run_i = 1'b0;
        step();
    endtask

    initial begin
        t_reset();
        t_order(2'b00, 1, 0, 0, "R2");
        t_order(2'b10, 0, 1, 0, "R3");
        t_order(2'b01, 0, 1, 1, "R4");
        t_order(2'b11, 1, 0, 0, "R5");
        t_abort_and_resample();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog (all requirements): actual=expired expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule